// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges every reset request of a small processor subsystem into one internal reset. The requests are a power-on pulse, an external active-low reset pin, a watchdog timeout, a power-fail detection and an illegal-address fault. Any of them sets a hold flop, and the internal reset then stays asserted. The pin must stay low for a minimum number of oscillator cycles before it counts. Shorter dips are treated as noise.

Once every request has gone away, a free-running interval counter of 2^TIMER_W cycles runs out and clears the hold flop. A short fixed tail of TAIL_LEN cycles follows, during which the core is still held. On the first cycle after the tail, a one-cycle strobe tells the core to load its program counter from the vector bytes at 16'hFFFE (low) and 16'hFFFF (high). A new request at any point during the countdown or the tail starts the whole sequence again.

Two configuration bits can turn the pin into a plain general input. A sticky cause log records which requests have been seen since software last cleared them. All logic runs on the oscillator clock, and the power-on pulse is the block's own synchronous active-low reset.

Top module: `rst_seq_top`

## Requirements
- R1: A high level on `wdt_to_i`, `pfail_i` or `addr_fault_i` at a rising edge, or a low level on `por_n_i`, makes `rst_int_o` high after that edge.
- R2: The pin is a reset request only after it has been sampled low at FILT_LEN (8) consecutive rising edges. `rst_int_o` then rises at the third edge after the eighth low sample. A low pulse of 7 or fewer samples has no effect on `rst_int_o`.
- R3: `rst_int_o` stays high while any request is active. It falls at the 2^TIMER_W-th consecutive rising edge at which no request is active. After power-on is released, `vec_fetch_o` therefore appears on the (2^TIMER_W + TAIL_LEN)-th edge.
- R4: A request that arrives during the countdown or the tail restarts the full countdown from zero.
- R5: `cpu_hold_o` is high whenever `rst_int_o` is high. It stays high for TAIL_LEN (7) further edges after `rst_int_o` falls.
- R6: `vec_fetch_o` is high for exactly one cycle. It rises at the edge where `cpu_hold_o` falls, and it is the signal to load the PC from 16'hFFFE/16'hFFFF.
- R7: When `cfg_por_en_i` and `cfg_pin_port_i` are both 1, the pin is not a reset source and `pin_in_o` shows the pin delayed by two edges. Otherwise `pin_in_o` is 1. `cfg_pin_port_i` alone leaves the pin acting as a reset.
- R8: `cause_o` bits are: bit0 power-on, bit1 pin, bit2 watchdog, bit3 power-fail, bit4 address-fault. A bit is set after an edge at which its request is active, and it stays set until a 1 on the same bit of `cause_clr_i`. If a set and a clear land on the same edge, the set wins.
- R9: While `por_n_i` is low, the outputs are `rst_int_o`=1, `cpu_hold_o`=1, `vec_fetch_o`=0, `cause_o`=5'b00001 and `pin_in_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_n_i | input | 1 | Power-on pulse, active low, also the block's synchronous reset |
| pin_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_to_i | input | 1 | Watchdog timeout request |
| pfail_i | input | 1 | Power-fail detection request |
| addr_fault_i | input | 1 | Illegal-address fault request |
| cfg_por_en_i | input | 1 | Configuration: power-on reset enabled |
| cfg_pin_port_i | input | 1 | Configuration: use the pin as a general input |
| cause_clr_i | input | 5 | Write-one-to-clear strobes for the cause log |
| rst_int_o | output | 1 | Internal reset; clears page register and flags, disables watchdog, power-fail detector and peripheral clock |
| cpu_hold_o | output | 1 | Core held: internal reset plus tail |
| vec_fetch_o | output | 1 | One-cycle strobe to load the PC from the reset vector |
| pin_in_o | output | 1 | Pin value when used as a general input |
| cause_o | output | 5 | Sticky reset-cause bits |

## Verification
The assertions assume three things about the inputs. The watchdog, power-fail and address-fault requests and the configuration bits are synchronous to the oscillator clock. `por_n_i` is held low for several cycles at start. The configuration bits change only after the pin has been high for several cycles, so the width filter is idle when the pin changes role. The bench keeps within these limits in three ways: it drives every input one nanosecond after a falling edge, it asserts power-on only at the start, and it allows a random configuration change only after six consecutive high pin cycles. Random request pulses and pin bursts of 1 to 14 cycles then land anywhere in the countdown and the tail.

// File: rtl/rst_seq_pkg.sv
// Shared definitions for the reset sequencer: request indices and the
// request vector type. Index order is the bit order of the cause log.
package rst_seq_pkg;
    localparam int SRC_POR   = 0;
    localparam int SRC_PIN   = 1;
    localparam int SRC_WDT   = 2;
    localparam int SRC_PFAIL = 3;
    localparam int SRC_ADDR  = 4;
    localparam int SRC_N     = 5;

    typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/pin_width_filter.sv
// Synchronises the asynchronous active-low reset pin and accepts it as a
// reset request only after FILT_LEN consecutive low samples.
// Assumes: SYNC_STAGES >= 2; port_mode_i is quasi-static.
module pin_width_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 8
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic pin_n_i,
    input  logic port_mode_i,
    output logic pin_req_o,
    output logic pin_sync_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       low_cnt_q;

    // Shift the raw pin through the synchroniser chain; idle level is high.
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
        end
    end

    assign pin_sync_o = sync_q[SYNC_STAGES-1];

    // Count consecutive low samples, saturating at FILT_LEN.
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            low_cnt_q <= '0;
        end else if (port_mode_i || pin_sync_o) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != CNT_W'(FILT_LEN)) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign pin_req_o = (low_cnt_q == CNT_W'(FILT_LEN));

    // R2: a request only starts after a low synchronised sample
    assert_req_needs_low_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(pin_req_o) |-> $past(!pin_sync_o));

    // R7: a pin configured as a general input never raises a request
    assert_port_blocks_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (port_mode_i && $past(port_mode_i)) |-> !pin_req_o);
endmodule

// File: rtl/rst_release_seq.sv
// Holds the internal reset while requests are active, then counts
// 2^TIMER_W quiet cycles, then a TAIL_LEN tail, then strobes the vector
// fetch for one cycle. Any request restarts the sequence.
// Assumes: TAIL_LEN >= 1; src_any_i excludes power-on (that is por_n_i).
module rst_release_seq #(
    parameter int TIMER_W  = 18,
    parameter int TAIL_LEN = 7
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic src_any_i,
    output logic rst_int_o,
    output logic hold_o,
    output logic vec_fetch_o
);
    localparam int TAIL_W = $clog2(TAIL_LEN + 1);

    logic               hold_q;
    logic [TIMER_W-1:0] itv_cnt_q;
    logic [TAIL_W-1:0]  tail_q;
    logic               vec_q;
    logic               ovf;

    assign ovf = hold_q && (itv_cnt_q == '1);

    // Set/reset hold flop: set by any request, cleared by timer overflow.
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            hold_q <= 1'b1;
        end else if (src_any_i) begin
            hold_q <= 1'b1;
        end else if (ovf) begin
            hold_q <= 1'b0;
        end
    end

    // Interval timer: cleared while any request is present, runs during hold.
    always_ff @(posedge clk_i) begin
        if (!por_n_i || src_any_i) begin
            itv_cnt_q <= '0;
        end else if (hold_q) begin
            itv_cnt_q <= itv_cnt_q + 1'b1;
        end
    end

    // Tail counter: loaded on overflow, counts down to zero.
    always_ff @(posedge clk_i) begin
        if (!por_n_i || src_any_i) begin
            tail_q <= '0;
        end else if (ovf) begin
            tail_q <= TAIL_W'(TAIL_LEN);
        end else if (tail_q != '0) begin
            tail_q <= tail_q - 1'b1;
        end
    end

    // Vector-fetch strobe on the cycle after the tail ends.
    always_ff @(posedge clk_i) begin
        if (!por_n_i) begin
            vec_q <= 1'b0;
        end else begin
            vec_q <= !src_any_i && (tail_q == TAIL_W'(1));
        end
    end

    assign rst_int_o   = hold_q;
    assign hold_o      = hold_q || (tail_q != '0);
    assign vec_fetch_o = vec_q;

    // R3: reset only ends after a cycle with no request
    assert_fall_quiet_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $fell(rst_int_o) |-> $past(!src_any_i));

    // R5: the core stays held when the internal reset ends
    assert_tail_after_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $fell(rst_int_o) |-> hold_o);

    // R6: the strobe lasts a single cycle
    assert_vec_single_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
        vec_fetch_o |=> !vec_fetch_o);

    // R6: the strobe coincides with the release of the core
    assert_vec_at_release_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
        vec_fetch_o |-> (!hold_o && $past(hold_o)));
endmodule

// File: rtl/rst_cause_log.sv
// Sticky per-source cause bits with write-one-to-clear; set beats clear.
// Power-on forces the log to show only the power-on bit.
// Assumes: src_i and clr_i are synchronous to clk_i.
module rst_cause_log
    import rst_seq_pkg::*;
(
    input  logic     clk_i,
    input  logic     por_n_i,
    input  src_vec_t src_i,
    input  src_vec_t clr_i,
    output src_vec_t cause_o
);
    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        logic bit_q;

        // Keep, clear or set one cause bit.
        always_ff @(posedge clk_i) begin
            if (!por_n_i) begin
                bit_q <= (i == SRC_POR);
            end else begin
                bit_q <= src_i[i] || (bit_q && !clr_i[i]);
            end
        end

        assign cause_o[i] = bit_q;
    end

    // R8: a recorded bit survives unless its clear strobe was given
    assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (($past(cause_o) & ~$past(clr_i) & ~cause_o) == '0));

    // R8: every active request is recorded on the next cycle
    assert_set_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
        ((cause_o & $past(src_i)) == $past(src_i)));
endmodule

// File: rtl/rst_seq_top.sv
// Top of the reset sequencer: merges the five requests, routes the pin
// either to the width filter or out as a general input, and drives the
// release sequence and the cause log.
// Assumes: watchdog, power-fail, address-fault and configuration inputs
// are synchronous to clk_i; por_n_i is held low for several cycles.
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int TIMER_W     = 18,
    parameter int TAIL_LEN    = 7,
    parameter int FILT_LEN    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       por_n_i,
    input  logic       pin_n_i,
    input  logic       wdt_to_i,
    input  logic       pfail_i,
    input  logic       addr_fault_i,
    input  logic       cfg_por_en_i,
    input  logic       cfg_pin_port_i,
    input  logic [4:0] cause_clr_i,
    output logic       rst_int_o,
    output logic       cpu_hold_o,
    output logic       vec_fetch_o,
    output logic       pin_in_o,
    output logic [4:0] cause_o
);
    logic     port_mode;
    logic     pin_req;
    logic     pin_sync;
    logic     src_any;
    src_vec_t src_vec;

    // Pin becomes a general input only with power-on reset also enabled.
    assign port_mode = cfg_pin_port_i && cfg_por_en_i;

    pin_width_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_filter (
        .clk_i      (clk_i),
        .por_n_i    (por_n_i),
        .pin_n_i    (pin_n_i),
        .port_mode_i(port_mode),
        .pin_req_o  (pin_req),
        .pin_sync_o (pin_sync)
    );

    // Collect requests in cause-log bit order.
    always_comb begin
        src_vec            = '0;
        src_vec[SRC_POR]   = !por_n_i;
        src_vec[SRC_PIN]   = pin_req;
        src_vec[SRC_WDT]   = wdt_to_i;
        src_vec[SRC_PFAIL] = pfail_i;
        src_vec[SRC_ADDR]  = addr_fault_i;
    end

    assign src_any = |src_vec[SRC_N-1:1];

    rst_release_seq #(
        .TIMER_W (TIMER_W),
        .TAIL_LEN(TAIL_LEN)
    ) u_seq (
        .clk_i      (clk_i),
        .por_n_i    (por_n_i),
        .src_any_i  (src_any),
        .rst_int_o  (rst_int_o),
        .hold_o     (cpu_hold_o),
        .vec_fetch_o(vec_fetch_o)
    );

    rst_cause_log u_cause (
        .clk_i  (clk_i),
        .por_n_i(por_n_i),
        .src_i  (src_vec),
        .clr_i  (cause_clr_i),
        .cause_o(cause_o)
    );

    assign pin_in_o = port_mode ? pin_sync : 1'b1;

    // R1: every accepted request asserts the internal reset on the next cycle
    assert_src_sets_R1: assert property (@(posedge clk_i) disable iff (!por_n_i)
        src_any |=> rst_int_o);

    // R5: the core is always held while the internal reset is active
    assert_hold_cover_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        rst_int_o |-> cpu_hold_o);
endmodule

// File: tb/rst_seq_top_tb.sv
`timescale 1ns/1ps
module rst_seq_top_tb;
    localparam int TW   = 6;
    localparam int TAIL = 7;
    localparam int QUIET = 1 << TW;

    logic clk = 1'b0;
    logic por_n = 1'b0, pin_n = 1'b1, wdt = 1'b0, pfail = 1'b0, afault = 1'b0;
    logic cfg_por = 1'b0, cfg_port = 1'b0;
    logic [4:0] clr = '0;
    logic rst_int, hold, vec, pin_in;
    logic [4:0] cause;

    int total = 0, bad = 0;
    bit done = 0, started = 0;

    always #2 clk = ~clk;

    rst_seq_top #(.TIMER_W(TW), .TAIL_LEN(TAIL)) u_dut (
        .clk_i(clk), .por_n_i(por_n), .pin_n_i(pin_n), .wdt_to_i(wdt),
        .pfail_i(pfail), .addr_fault_i(afault), .cfg_por_en_i(cfg_por),
        .cfg_pin_port_i(cfg_port), .cause_clr_i(clr), .rst_int_o(rst_int),
        .cpu_hold_o(hold), .vec_fetch_o(vec), .pin_in_o(pin_in), .cause_o(cause));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements, advanced at each edge.
    bit m_rst = 1, m_strobe = 0;
    int m_quiet = 0, m_tail = 0, m_run = 0;
    bit [2:0] m_pipe = '0;
    bit m_d1 = 1, m_d2 = 1;
    logic [4:0] m_cause = 5'b00001;

    function automatic bit port_mode_f(input logic por_en, input logic port);
        return por_en && port;
    endfunction

    function automatic int sat_run(input int run, input bit low);
        return low ? ((run < 8) ? run + 1 : 8) : 0;
    endfunction

    always @(posedge clk) begin
        bit psrc, src;
        logic [4:0] sv;
        if (!por_n) begin
            m_rst = 1; m_quiet = 0; m_tail = 0; m_strobe = 0; m_run = 0;
            m_pipe = '0; m_d1 = 1; m_d2 = 1; m_cause = 5'b00001;
        end else begin
            m_run = sat_run(m_run, !pin_n && !port_mode_f(cfg_por, cfg_port));
            psrc = m_pipe[2];
            m_pipe = {m_pipe[1:0], (m_run >= 8)};
            m_d2 = m_d1; m_d1 = pin_n;
            src = psrc || wdt || pfail || afault;
            sv = {afault, pfail, wdt, psrc, 1'b0};
            m_cause = (m_cause & ~clr) | sv;
            m_strobe = 0;
            if (src) begin
                m_rst = 1; m_quiet = 0; m_tail = 0;
            end else if (m_rst) begin
                m_quiet++;
                if (m_quiet == QUIET) begin m_rst = 0; m_tail = TAIL; end
            end else if (m_tail > 0) begin
                m_tail--;
                if (m_tail == 0) m_strobe = 1;
            end
        end
    end

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            logic exp_pin;
            exp_pin = port_mode_f(cfg_por, cfg_port) ? m_d2 : 1'b1;
            chk(rst_int === m_rst, "R3 R4 rst_int_o", rst_int, m_rst);
            chk(hold === (m_rst || m_tail != 0), "R5 cpu_hold_o", hold, (m_rst || m_tail != 0));
            chk(vec === m_strobe, "R6 vec_fetch_o", vec, m_strobe);
            chk(cause === m_cause, "R8 cause_o", cause, m_cause);
            chk(pin_in === exp_pin, "R7 pin_in_o", pin_in, exp_pin);
        end
    end

    task automatic step_drive();
        @(negedge clk); #1;
    endtask

    task automatic wait_idle();
        while (hold || vec) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pin_low(input int len);
        step_drive(); pin_n = 0;
        repeat (len) @(negedge clk);
        #1 pin_n = 1;
    endtask

    function automatic bit saw_rise(input bit seen);
        return seen;
    endfunction

    task automatic watch_rst(output bit seen, input int n);
        seen = 0;
        repeat (n) begin @(negedge clk); seen |= rst_int; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit seen;
        int k;
        int seed;
        int burst = 0, hi_run = 0;
        seed = $urandom(32'h5EED_0042);
        started = 1;
        repeat (4) @(negedge clk);
        // R9: state while power-on is held
        chk(rst_int === 1 && hold === 1, "R9 reset/hold", {rst_int, hold}, 3);
        chk(vec === 0, "R9 vec_fetch_o", vec, 0);
        chk(cause === 5'b00001 && pin_in === 1, "R9 cause/pin_in", {cause, pin_in}, 3);
        #1 por_n = 1;
        // R3: release timing after power-on
        k = 0;
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            if (vec) begin k = i; break; end
        end
        chk(k == QUIET + TAIL, "R3 release cycles", k, QUIET + TAIL);
        wait_idle();

        // R1: each hardware request asserts reset on the next cycle
        for (int s = 0; s < 3; s++) begin
            step_drive();
            wdt = (s == 0); pfail = (s == 1); afault = (s == 2);
            @(negedge clk);
            chk(rst_int === 1, "R1 request sets rst_int_o", rst_int, 1);
            #1 wdt = 0; pfail = 0; afault = 0;
            wait_idle();
        end

        // R2: 7-sample pulse is noise, 8-sample pulse is a reset
        pin_low(7);
        watch_rst(seen, 6);
        chk(seen == 0, "R2 short pulse ignored", seen, 0);
        wait_idle();
        pin_low(8);
        watch_rst(seen, 3);
        chk(seen == 1, "R2 8-sample pulse accepted", seen, 1);
        wait_idle();

        // R4: a second request restarts the countdown
        step_drive(); wdt = 1;
        step_drive(); wdt = 0;
        repeat (40) @(negedge clk);
        #1 pfail = 1;
        step_drive(); pfail = 0;
        repeat (40) @(negedge clk);
        chk(rst_int === 1, "R4 restart extends reset", rst_int, 1);
        wait_idle();

        // R7: pin as general input, then pin-port bit alone
        step_drive(); cfg_por = 1; cfg_port = 1;
        repeat (4) @(negedge clk);
        #1 pin_n = 0;
        repeat (5) @(negedge clk);
        chk(pin_in === 0, "R7 pin_in_o follows pin", pin_in, 0);
        repeat (15) @(negedge clk);
        #1 pin_n = 1;
        watch_rst(seen, 8);
        chk(seen == 0, "R7 port mode no reset", seen, 0);
        chk(pin_in === 1, "R7 pin_in_o high again", pin_in, 1);
        step_drive(); cfg_por = 0;
        repeat (4) @(negedge clk);
        pin_low(10);
        watch_rst(seen, 4);
        chk(seen == 1, "R7 port bit alone keeps reset", seen, 1);
        wait_idle();
        step_drive(); cfg_port = 0;

        // R8: clear, then set, then set-beats-clear
        step_drive(); clr = 5'h1F;
        step_drive(); clr = 5'h00;
        @(negedge clk);
        chk(cause === 5'b00000, "R8 cleared", cause, 0);
        #1 afault = 1;
        step_drive(); afault = 0;
        chk(cause === 5'b10000, "R8 address bit set", cause, 5'b10000);
        wait_idle();
        step_drive(); wdt = 1; clr = 5'b00100;
        step_drive(); wdt = 0; clr = 5'b00000;
        chk(cause[2] === 1, "R8 set beats clear", cause[2], 1);
        wait_idle();

        // Random phase, checked by the model on every cycle.
        for (int c = 0; c < 12000; c++) begin
            step_drive();
            wdt = ($urandom % 250) == 0;
            pfail = ($urandom % 300) == 0;
            afault = ($urandom % 300) == 0;
            clr = (($urandom % 40) == 0) ? 5'($urandom) : 5'b0;
            if (burst > 0) begin
                pin_n = 0; burst--;
            end else begin
                pin_n = 1;
                if (($urandom % 120) == 0) burst = 1 + ($urandom % 14);
            end
            hi_run = pin_n ? hi_run + 1 : 0;
            if (hi_run >= 6 && burst == 0 && ($urandom % 400) == 0) begin
                cfg_por = $urandom;
                cfg_port = $urandom;
            end
        end
        step_drive();
        wdt = 0; pfail = 0; afault = 0; clr = 0; pin_n = 1;
        repeat (5) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule